// File: doc/BRIEF.md
# Watchdog Wakeup Reset Sequencer

This block supervises a host microcontroller. It drives an active-low host reset and a periodic wakeup square wave that interrupts a sleeping processor. The host answers each wakeup by toggling a watchdog line low. The block watches for falling edges on that line. It holds the host in reset at power-up and while an undervoltage flag is raised. It also resets the host when a whole wakeup cycle passes without a watchdog edge.

All intervals come from one unit interval U, counted in system clock cycles. U is the base count input (a base of zero counts as one), multiplied by three when the slow-timing select is high. The reset release delay is U. The delay from reset release to the first wakeup is 4U. A wakeup cycle lasts 8U: the output is high for 4U, then low for 4U. A small glitch filter of FILT_LEN cycles sits behind a two-stage synchronizer on the watchdog line. Both stages reset to the idle-high level.

Top module: `wdt_wake_seq`

## Requirements
- R1: After rst_ni is released with uv_i low, and after uv_i clears, host_rst_no stays low for U more cycles and rises in cycle U+1. U = max(base_i,1) when slow_i=0.
- R2: While uv_i is high, host_rst_no and wake_o are low from the next cycle on, whatever the state. Any wakeup cycle in progress is abandoned.
- R3: After host_rst_no rises, wake_o stays low for 4U cycles and then goes high. Watchdog edges do not change this delay.
- R4: While a filtered watchdog falling edge arrives in the low half of every cycle, wake_o alternates 4U cycles high and 4U cycles low, and host_rst_no stays high.
- R5: The first filtered falling edge in the high half drives wake_o low in the (FILT_LEN+3)-th cycle after wdi_i falls. wake_o stays low until the next cycle begins, 8U cycles after the cycle's rising edge.
- R6: Further falling edges within the same cycle are ignored. An edge seen in one cycle does not count for the next cycle.
- R7: If a cycle of 8U ends with no filtered falling edge, host_rst_no goes low for U cycles and wake_o is low. The sequence then restarts with the 4U wakeup delay.
- R8: slow_i=1 makes U three times max(base_i,1), which scales every interval.
- R9: A low pulse on wdi_i shorter than FILT_LEN cycles is not registered as an edge. A low pulse of FILT_LEN cycles or more is registered.
- R10: Falling edges during reset or during the 4U wakeup delay do not count toward the first wakeup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wdi_i | input | 1 | Watchdog line from the host; its falling edges are counted |
| uv_i | input | 1 | Undervoltage flag, active high, synchronous to clk_i |
| slow_i | input | 1 | Timing option: 0 = 1x, 1 = 3x |
| base_i | input | BASE_W | Base count of clock cycles per unit interval |
| wake_o | output | 1 | Wakeup square wave to the host |
| host_rst_no | output | 1 | Reset to the host, active low |

## Verification
The assertions assume that base_i and slow_i change only while the block is in reset or undervoltage. They also assume that uv_i is already synchronous to clk_i. The interval-counter bound would fail if the programmed length shrank in the middle of an interval. The stimulus therefore raises uv_i for a cycle before it reprograms the timing inputs. Every wdi_i pulse meant to count is FILT_LEN+2 cycles wide, and its high phase is just as long or longer. Every pulse meant to be dropped is narrower than FILT_LEN.

// File: rtl/wws_pkg.sv
package wws_pkg;
  typedef enum logic [2:0] {
    ST_RST,
    ST_HOLD,
    ST_PRE,
    ST_HIGH,
    ST_LOW
  } wws_state_e;

  localparam int unsigned PRE_SHIFT  = 2;  // wake delay = 4 units
  localparam int unsigned HALF_SHIFT = 2;  // each half cycle = 4 units
endpackage

// File: rtl/wws_wdi_filter.sv
module wws_wdi_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], wdi_i};
      if (sync_q[1] != lvl_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          lvl_q  <= sync_q[1];
          cnt_q  <= '0;
          fall_q <= ~sync_q[1];
        end else begin
          cnt_q  <= cnt_q + CW'(1);
          fall_q <= 1'b0;
        end
      end else begin
        cnt_q  <= '0;
        fall_q <= 1'b0;
      end
    end
  end

  assign fall_o = fall_q;

  assert_fall_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/wws_timer.sv
module wws_timer #(
  parameter int unsigned LEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + LEN_W'(1);
  end

  assign done_o = (cnt_q == len_i - LEN_W'(1));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q < len_i);
endmodule

// File: rtl/wdt_wake_seq.sv
module wdt_wake_seq
  import wws_pkg::*;
#(
  parameter int unsigned BASE_W   = 16,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdi_i,
  input  logic              uv_i,
  input  logic              slow_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              wake_o,
  output logic              host_rst_no
);
  localparam int unsigned UNIT_W = BASE_W + 2;
  localparam int unsigned LEN_W  = UNIT_W + 2;

  wws_state_e       state_q, state_d;
  logic             seen_q, seen_d;
  logic             fall, done, clr;
  logic [UNIT_W-1:0] base_eff, unit;
  logic [LEN_W-1:0]  len;

  wws_wdi_filter #(.FILT_LEN(FILT_LEN)) i_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wdi_i  (wdi_i),
    .fall_o (fall)
  );

  always_comb begin
    base_eff = (base_i == '0) ? UNIT_W'(1) : UNIT_W'(base_i);
    unit     = slow_i ? base_eff + (base_eff << 1) : base_eff;
    unique case (state_q)
      ST_PRE:           len = LEN_W'(unit) << PRE_SHIFT;
      ST_HIGH, ST_LOW:  len = LEN_W'(unit) << HALF_SHIFT;
      default:          len = LEN_W'(unit);
    endcase
  end

  wws_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .len_i  (len),
    .done_o (done)
  );

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    unique case (state_q)
      ST_RST: begin
        seen_d = 1'b0;
        if (!uv_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        seen_d = 1'b0;
        if (done) state_d = ST_PRE;
      end
      ST_PRE: begin
        seen_d = 1'b0;
        if (done) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (fall) seen_d = 1'b1;
        if (done) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (fall) seen_d = 1'b1;
        if (done) begin
          // cycle boundary: an edge in the last cycle still counts
          state_d = (seen_q || fall) ? ST_HIGH : ST_HOLD;
          seen_d  = 1'b0;
        end
      end
      default: state_d = ST_RST;
    endcase
    if (uv_i) begin
      state_d = ST_RST;
      seen_d  = 1'b0;
    end
  end

  assign clr = (state_d != state_q) || (state_q == ST_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

  assign host_rst_no = (state_q == ST_PRE) || (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign wake_o      = (state_q == ST_HIGH) && !seen_q;

  assert_uv_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (!host_rst_no && !wake_o));

  assert_no_wake_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rst_no |-> !wake_o);

  assert_trunc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && !wake_o) |=> !wake_o);

  assert_rise_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(state_q) == ST_PRE || $past(state_q) == ST_LOW));

  assert_rst_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_no) |-> ($past(state_q) == ST_HOLD && !$past(uv_i)));
endmodule

// File: tb/test_wdt_wake_seq.sv
module test_wdt_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int FL = 3;
  localparam int NV = 4;
  // base, slow, expected unit
  localparam int VEC [NV][3] = '{'{4, 0, 4}, '{2, 1, 6}, '{5, 0, 5}, '{3, 1, 9}};

  logic clk = 1'b0, rst_ni = 1'b0, wdi = 1'b1, uv = 1'b0, slow = 1'b0;
  logic [BW-1:0] base = '0;
  logic wake, rstn;
  int cyc = 0, total = 0, bad = 0;

  wdt_wake_seq #(.BASE_W(BW), .FILT_LEN(FL)) i_wdt_wake_seq (
    .clk_i(clk), .rst_ni(rst_ni), .wdi_i(wdi), .uv_i(uv), .slow_i(slow),
    .base_i(base), .wake_o(wake), .host_rst_no(rstn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sig(input bit sel, input bit val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((sel ? wake : rstn) != val) && n < 2000);
  endtask

  task automatic pulse(input int w);
    wdi = 1'b0;
    step(w);
    wdi = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, u, t;
    step(2);
    check(rstn == 0 && wake == 0, "R1", "outputs in power-on reset", {rstn, wake}, 0);
    rst_ni = 1'b1;                       // base 0 -> unit 1
    wait_sig(0, 1, n);
    check(n == 2, "R1", "release with base 0", n, 2);
    wait_sig(1, 1, n);
    check(n == 4, "R3", "wake delay unit 1", n, 4);

    for (int i = 0; i < NV; i++) begin
      u = VEC[i][2];
      uv = 1'b1;
      step(1);
      check(rstn == 0 && wake == 0, "R2", "uv forces reset", {rstn, wake}, 0);
      base = BW'(VEC[i][0]);
      slow = VEC[i][1][0];
      step(2);
      uv = 1'b0;
      wait_sig(0, 1, n);
      check(n == u + 1, "R8", "release after uv", n, u + 1);
      wait_sig(1, 1, n);
      check(n == 4 * u, "R3", "wake delay", n, 4 * u);
      wait_sig(1, 0, n);
      check(n == 4 * u, "R4", "high half", n, 4 * u);
      pulse(FL + 2);
      wait_sig(1, 1, n);
      check(n == 4 * u - (FL + 2), "R4", "low half with edge", n, 4 * u - (FL + 2));
      wait_sig(1, 0, n);
      check(n == 4 * u, "R4", "second high half", n, 4 * u);
      wait_sig(0, 0, n);
      check(n == 4 * u, "R7", "reset at end of missed cycle", n, 4 * u);
      check(wake == 0, "R7", "wake low in reset", wake, 0);
      wait_sig(0, 1, n);
      check(n == u, "R7", "missed-edge reset width", n, u);
      wait_sig(1, 1, n);
      check(n == 4 * u, "R7", "restart wake delay", n, 4 * u);
    end

    // directed: unit 8
    u = 8;
    uv = 1'b1;
    step(1);
    base = BW'(8);
    slow = 1'b0;
    step(1);
    uv = 1'b0;
    wait_sig(0, 1, n);
    wait_sig(1, 1, n);
    t = cyc;
    step(4);
    wdi = 1'b0;
    wait_sig(1, 0, n);
    check(n == FL + 3, "R5", "truncation latency", n, FL + 3);
    wdi = 1'b1;
    step(6);
    pulse(FL + 2);                       // duplicate edge, same cycle
    wait_sig(1, 1, n);
    check(cyc - t == 8 * u, "R5", "next cycle start", cyc - t, 8 * u);
    check(rstn == 1, "R6", "duplicate edge causes no reset", rstn, 1);
    t = cyc;
    wait_sig(0, 0, n);
    check(cyc - t == 8 * u, "R6", "edge not carried over", cyc - t, 8 * u);
    check(wake == 0, "R7", "wake low at missed reset", wake, 0);
    wait_sig(0, 1, n);
    check(n == u, "R7", "reset width unit 8", n, u);

    step(2);
    pulse(FL + 2);                       // edge during wake delay
    wait_sig(1, 1, n);
    check(n == 4 * u - 2 - (FL + 2), "R10", "wake delay unchanged", n, 4 * u - 2 - (FL + 2));
    t = cyc;
    step(3);
    pulse(1);
    step(3);
    pulse(FL - 1);                       // glitches only
    wait_sig(1, 0, n);
    check(cyc - t == 4 * u, "R9", "glitches do not truncate", cyc - t, 4 * u);
    wait_sig(0, 0, n);
    check(cyc - t == 8 * u, "R10", "pre-delay edge not counted", cyc - t, 8 * u);

    wait_sig(0, 1, n);
    wait_sig(1, 1, n);
    step(3);
    uv = 1'b1;
    step(1);
    check(rstn == 0 && wake == 0, "R2", "uv abort mid-cycle", {rstn, wake}, 0);
    uv = 1'b0;
    wait_sig(0, 1, n);
    check(n == u + 1, "R2", "release after abort", n, u + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule